// File: doc/BRIEF.md
# Prescaled Compare Timer with Reset Watchdog

This block is a 16-bit up/down counter driven by a power-of-two prescaler. Two compare registers are matched against the counter. Each comparator has its own 2-bit mode, and each has a sticky flag that software clears by writing 1 to it. The counter returns to zero on the first prescaled tick after it equals compare 2. This makes compare 2 the period register of a repeating count.

Software reaches four 16-bit registers through a single-cycle write strobe and a combinational read port. Used as a watchdog, the block works like this. Software enables counting with compare 2 in a flagging mode, clears the counter, and loads a nonzero period into compare 2. It then keeps rewriting the counter to zero before the period runs out. If the compare 2 flag rises while the external reset-enable input is high, the block raises a one-cycle system-reset request.

Top module: `cmpt_top`

## Requirements
- R1: Byte addresses 0, 2, 4 and 6 select compare 1, compare 2, the counter and the setup register. Writes to an odd address are ignored, and reads from an odd address return 0. After reset every register reads 0, and irq and sys_rst_req are 0.
- R2: While setup bit 15 (count enable) is 1, the counter moves once every 2^n clocks, where n is setup bits [3:0]. A write to the counter restarts this prescale phase.
- R3: While count enable is 0, the counter holds its value. A write to the counter loads the written value.
- R4: Setup bit 5 (reverse) makes the counter count down instead of up. Setup bit 4 (clock select) is stored and read back but has no effect.
- R5: On a prescaled tick where the counter equals compare 2, the counter becomes 0. This happens whatever the compare modes are.
- R6: The compare 1 mode is in setup bits [7:6] and the compare 2 mode is in bits [9:8]. The codes are: 00 off, 01 set the flag while counter == compare, 10 set the flag while counter >= compare, 11 event. The flag rises one clock after the condition holds. Flag 1 reads at setup bit 13 and flag 2 at setup bit 14.
- R7: In event mode (11), the flag is set only on a prescaled tick at which the counter equals the compare value.
- R8: Writing 1 to a flag bit in a setup write clears that flag. Writing 0 leaves it unchanged. If a set condition holds in the same cycle as the clear, the flag stays set.
- R9: With setup bit 11 (stop) set, counting and the prescaler halt while flag 2 is set. Counting resumes after flag 2 is cleared.
- R10: Setup bit 12 reads 1 after the first setup write and cannot be cleared by software. Setup bit 10 always reads 0.
- R11: irq is 1 exactly when flag 1 or flag 2 is set.
- R12: sys_rst_req pulses for one cycle, in the same cycle that flag 2 first reads 1. It pulses only if rst_en was 1 and compare 2 was nonzero when flag 2 rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte address of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for addr |
| rst_en | input | 1 | Lets a compare 2 flag rise request a system reset |
| irq | output | 1 | OR of the two compare flags |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
A register write takes effect at the clock edge that samples it. A counter step lands on every 2^n-th edge after counting starts or after a counter write. A flag reads set one edge after its condition holds, and the reset request appears in that same cycle. The directed sequences count whole clock edges from the end of each write to the cycle where each result is due, and sample only there. A per-cycle reference model, advanced at every rising edge from the requirements, is compared with rd_data, irq and sys_rst_req late in each low phase. This comparison runs through the directed phase and through a seeded random run that mixes writes to every address.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    localparam int REG_W     = 16;
    localparam int EXP_W     = 4;
    localparam int ADDR_W    = 3;
    localparam int FLAG1_BIT = 13;
    localparam int FLAG2_BIT = 14;

    typedef enum logic [1:0] {
        CMP_OFF = 2'b00,
        CMP_EQ  = 2'b01,
        CMP_GE  = 2'b10,
        CMP_EVT = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        SEL_CMP1  = 2'd0,
        SEL_CMP2  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_SETUP = 2'd3
    } reg_sel_e;

    // setup word, MSB first
    typedef struct packed {
        logic             cnt_en;   // 15
        logic             flag2;    // 14
        logic             flag1;    // 13
        logic             done;     // 12
        logic             stop_en;  // 11
        logic             rsvd;     // 10
        cmp_mode_e        mode2;    // 9:8
        cmp_mode_e        mode1;    // 7:6
        logic             rev;      // 5
        logic             clksel;   // 4
        logic [EXP_W-1:0] exp;      // 3:0
    } setup_t;

    function automatic logic cmp_hit(cmp_mode_e mode, logic [REG_W-1:0] cnt,
                                     logic [REG_W-1:0] ref_val, logic tick);
        case (mode)
            CMP_EQ:  return cnt == ref_val;
            CMP_GE:  return cnt >= ref_val;
            CMP_EVT: return tick && (cnt == ref_val);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmpt_prescaler.sv
module cmpt_prescaler #(
    parameter int EXP_W = cmpt_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);
    localparam int PRE_W = (1 << EXP_W) - 1;
    localparam logic [PRE_W-1:0] ONES = '1;

    logic [PRE_W-1:0] acc_q;
    logic [PRE_W-1:0] mask;

    assign mask = ONES >> (PRE_W - int'(exp));
    assign tick = run && ((acc_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            acc_q <= '0;
        else
            acc_q <= acc_q + PRE_W'(1);
    end
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
    parameter int W = cmpt_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         tick,
    input  logic         rev,
    input  logic [W-1:0] wrap_at,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (ld)
            count <= ld_val;
        else if (tick) begin
            if (count == wrap_at)
                count <= '0;
            else if (rev)
                count <= count - W'(1);
            else
                count <= count + W'(1);
        end
    end
endmodule

// File: rtl/cmpt_cmp_flag.sv
module cmpt_cmp_flag
    import cmpt_pkg::*;
#(
    parameter int W = cmpt_pkg::REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cmp_mode_e    mode,
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    input  logic         tick,
    input  logic         clr,
    output logic         flag,
    output logic         rise
);
    logic set;

    assign set  = cmp_hit(mode, count, ref_val, tick);
    assign rise = set && !flag;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= (flag && !clr) || set;
    end
endmodule

// File: rtl/cmpt_top.sv
module cmpt_top
    import cmpt_pkg::*;
#(
    parameter int REG_W  = cmpt_pkg::REG_W,
    parameter int ADDR_W = cmpt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              rst_en,
    output logic              irq,
    output logic              sys_rst_req
);
    localparam int NCMP = 2;

    reg_sel_e         sel;
    logic             hit_even;
    logic             wr_cnt, wr_setup;
    logic [REG_W-1:0] cmp_q [NCMP];
    setup_t           setup_q;
    setup_t           setup_rd;
    cmp_mode_e        mode_a [NCMP];
    logic             clr_a  [NCMP];
    logic             flag_a [NCMP];
    logic             rise_a [NCMP];
    logic             tick, run, cnt_en;
    logic [REG_W-1:0] count_q;

    assign sel      = reg_sel_e'(addr[2:1]);
    assign hit_even = !addr[0];
    assign wr_cnt   = wr_en && hit_even && (sel == SEL_COUNT);
    assign wr_setup = wr_en && hit_even && (sel == SEL_SETUP);

    // compare registers
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[i] <= '0;
            else if (wr_en && hit_even && (sel == reg_sel_e'(i)))
                cmp_q[i] <= wr_data;
        end
    end

    // setup register (flags live in the compare units)
    always_ff @(posedge clk) begin
        if (rst)
            setup_q <= '0;
        else if (wr_setup) begin
            setup_q       <= setup_t'(wr_data);
            setup_q.flag1 <= 1'b0;
            setup_q.flag2 <= 1'b0;
            setup_q.rsvd  <= 1'b0;
            setup_q.done  <= 1'b1;
        end
    end

    assign cnt_en = setup_q.cnt_en;
    assign run    = cnt_en && !(setup_q.stop_en && flag_a[1]);

    cmpt_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (wr_cnt),
        .exp     (setup_q.exp),
        .tick    (tick)
    );

    cmpt_counter #(.W(REG_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ld      (wr_cnt),
        .ld_val  (wr_data),
        .tick    (tick),
        .rev     (setup_q.rev),
        .wrap_at (cmp_q[1]),
        .count   (count_q)
    );

    assign mode_a[0] = setup_q.mode1;
    assign mode_a[1] = setup_q.mode2;
    assign clr_a[0]  = wr_setup && wr_data[FLAG1_BIT];
    assign clr_a[1]  = wr_setup && wr_data[FLAG2_BIT];

    for (genvar i = 0; i < NCMP; i++) begin : g_flag
        cmpt_cmp_flag #(.W(REG_W)) u_flag (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode_a[i]),
            .count   (count_q),
            .ref_val (cmp_q[i]),
            .tick    (tick),
            .clr     (clr_a[i]),
            .flag    (flag_a[i]),
            .rise    (rise_a[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            sys_rst_req <= 1'b0;
        else
            sys_rst_req <= rise_a[1] && rst_en && (cmp_q[1] != '0);
    end

    assign irq = flag_a[0] || flag_a[1];

    always_comb begin
        setup_rd       = setup_q;
        setup_rd.flag1 = flag_a[0];
        setup_rd.flag2 = flag_a[1];
        setup_rd.rsvd  = 1'b0;
    end

    always_comb begin
        rd_data = '0;
        if (hit_even) begin
            case (sel)
                SEL_CMP1:  rd_data = cmp_q[0];
                SEL_CMP2:  rd_data = cmp_q[1];
                SEL_COUNT: rd_data = count_q;
                default:   rd_data = REG_W'(setup_rd);
            endcase
        end
    end
endmodule

// File: rtl/cmpt_checker.sv
module cmpt_checker #(
    parameter int REG_W  = cmpt_pkg::REG_W,
    parameter int ADDR_W = cmpt_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rst_en,
    input logic              sys_rst_req,
    input logic              cnt_en,
    input logic              tick,
    input logic              rev,
    input logic              flag2,
    input logic [REG_W-1:0]  count,
    input logic [REG_W-1:0]  cmp2
);
    logic ld;
    assign ld = wr_en && (addr == ADDR_W'(4));

    p_pulse_single_r12: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    p_pulse_gated_r12: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> ($past(rst_en) && ($past(cmp2) != '0)));

    p_pulse_with_flag_r12: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> flag2);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !ld) |=> $stable(count));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && (count == cmp2) && !ld) |=> (count == '0));

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !rev && (count != cmp2) && !ld) |=> (count == REG_W'($past(count) + 1)));
endmodule

bind cmpt_top cmpt_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .rst_en      (rst_en),
    .sys_rst_req (sys_rst_req),
    .cnt_en      (cnt_en),
    .tick        (tick),
    .rev         (setup_q.rev),
    .flag2       (flag_a[1]),
    .count       (count_q),
    .cmp2        (cmp_q[1])
);

// File: tb/cmpt_top_tb_top.sv
module cmpt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rst_en = 1'b0;
    logic        irq;
    logic        sys_rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    cmpt_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rst_en(rst_en), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    // ---------------- reference model (from requirements) ----------------
    logic [15:0] m_cmp1, m_cmp2, m_cnt;
    logic [3:0]  m_exp;
    logic [1:0]  m_mode1, m_mode2;
    bit          m_clksel, m_rev, m_stop, m_done, m_en, m_f1, m_f2, m_pulse;
    int          m_acc;

    function automatic bit m_hit(logic [1:0] md, logic [15:0] c, logic [15:0] v, bit t);
        case (md)
            2'b01:   return c == v;
            2'b10:   return c >= v;
            2'b11:   return t && (c == v);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_setup();
        return {m_en, m_f2, m_f1, m_done, m_stop, 1'b0, m_mode2, m_mode1,
                m_rev, m_clksel, m_exp};
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a);
        if (a[0]) return 16'h0;
        case (a[2:1])
            2'd0:    return m_cmp1;
            2'd1:    return m_cmp2;
            2'd2:    return m_cnt;
            default: return m_setup();
        endcase
    endfunction

    always @(posedge clk) begin
        bit run, tick, h1, h2, wc, ws;
        int mask;
        if (rst) begin
            m_cmp1 = 0; m_cmp2 = 0; m_cnt = 0; m_exp = 0; m_mode1 = 0; m_mode2 = 0;
            m_clksel = 0; m_rev = 0; m_stop = 0; m_done = 0; m_en = 0;
            m_f1 = 0; m_f2 = 0; m_pulse = 0; m_acc = 0;
        end else begin
            run  = m_en && !(m_stop && m_f2);
            mask = (1 << m_exp) - 1;
            tick = run && ((m_acc & mask) == mask);
            wc   = wr_en && !addr[0] && addr[2:1] == 2'd2;
            ws   = wr_en && !addr[0] && addr[2:1] == 2'd3;
            h1   = m_hit(m_mode1, m_cnt, m_cmp1, tick);
            h2   = m_hit(m_mode2, m_cnt, m_cmp2, tick);
            m_pulse = h2 && !m_f2 && rst_en && (m_cmp2 != 0);
            m_f1 = (m_f1 && !(ws && wr_data[13])) || h1;
            m_f2 = (m_f2 && !(ws && wr_data[14])) || h2;
            if (wc) m_cnt = wr_data;
            else if (tick) m_cnt = (m_cnt == m_cmp2) ? 16'h0 : (m_rev ? m_cnt - 16'h1 : m_cnt + 16'h1);
            m_acc = (wc || !run) ? 0 : ((m_acc + 1) & 32'h7fff);
            if (wr_en && !addr[0] && addr[2:1] == 2'd0) m_cmp1 = wr_data;
            if (wr_en && !addr[0] && addr[2:1] == 2'd1) m_cmp2 = wr_data;
            if (ws) begin
                m_en = wr_data[15]; m_done = 1; m_stop = wr_data[11];
                m_mode2 = wr_data[9:8]; m_mode1 = wr_data[7:6];
                m_rev = wr_data[5]; m_clksel = wr_data[4]; m_exp = wr_data[3:0];
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle model comparison, late in the low phase
    always begin
        @(negedge clk);
        #8;
        if (!rst && !finished) begin
            chk("R1 rd_data vs model", rd_data, m_read(addr));
            chk("R11 irq vs model", {15'h0, irq}, {15'h0, (m_f1 | m_f2)});
            chk("R12 sys_rst_req vs model", {15'h0, sys_rst_req}, {15'h0, m_pulse});
        end
    end

    // called at a negedge; the write is sampled by the next rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #2;
        v = rd_data;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic quiesce();
        wr(3'd6, 16'h0000);
        wr(3'd6, 16'h6000);
        wr(3'd4, 16'h0000);
    endtask

    task automatic count_pulses(input int k, output int n);
        n = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            #2;
            if (sys_rst_req) n++;
        end
    endtask

    // watchdog
    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int seen, np;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 reset cmp1", v, 16'h0);
        rd(3'd2, v); chk("R1 reset cmp2", v, 16'h0);
        rd(3'd4, v); chk("R1 reset counter", v, 16'h0);
        rd(3'd6, v); chk("R1 reset setup", v, 16'h0);
        chk("R1 reset irq", {15'h0, irq}, 16'h0);
        chk("R1 reset sys_rst_req", {15'h0, sys_rst_req}, 16'h0);
        @(negedge clk);

        // R1 map and odd addresses
        wr(3'd0, 16'h1234); wr(3'd2, 16'hBEEF);
        rd(3'd0, v); chk("R1 cmp1 readback", v, 16'h1234);
        rd(3'd2, v); chk("R1 cmp2 readback", v, 16'hBEEF);
        @(negedge clk);
        wr(3'd1, 16'h5555);
        rd(3'd0, v); chk("R1 odd write ignored", v, 16'h1234);
        rd(3'd1, v); chk("R1 odd read zero", v, 16'h0);
        @(negedge clk);

        // R10 done bit, R4 clock select stored
        wr(3'd6, 16'h0430);
        rd(3'd6, v); chk("R10 done set, rsvd zero, R4 clksel stored", v, 16'h1030);
        @(negedge clk);

        // R3 hold while disabled
        wr(3'd6, 16'h0000);
        wr(3'd4, 16'h0007); idle(5);
        rd(3'd4, v); chk("R3 counter holds when disabled", v, 16'h0007);
        @(negedge clk);
        wr(3'd2, 16'hFFFF);

        // R2 prescale
        quiesce(); wr(3'd6, 16'h8000); idle(5);
        rd(3'd4, v); chk("R2 exp0 step per clock", v, 16'd5);
        @(negedge clk);
        quiesce(); wr(3'd6, 16'h8003); idle(20);
        rd(3'd4, v); chk("R2 exp3 step per 8 clocks", v, 16'd2);
        @(negedge clk);
        quiesce(); wr(3'd6, 16'h8002); idle(12);
        rd(3'd4, v); chk("R2 exp2 step per 4 clocks", v, 16'd3);
        @(negedge clk);
        wr(3'd4, 16'h0010); idle(7);
        rd(3'd4, v); chk("R2 phase restart on counter write", v, 16'h0011);
        @(negedge clk);

        // R4 reverse and clock select
        quiesce(); wr(3'd4, 16'd10); wr(3'd6, 16'h8020); idle(4);
        rd(3'd4, v); chk("R4 reverse counts down", v, 16'd6);
        @(negedge clk);
        quiesce(); wr(3'd6, 16'h8010); idle(4);
        rd(3'd4, v); chk("R4 clock select no effect", v, 16'd4);
        @(negedge clk);

        // R5 reload on compare 2
        quiesce(); wr(3'd2, 16'd3); wr(3'd6, 16'h8000); idle(4);
        rd(3'd4, v); chk("R5 reload to zero after match", v, 16'd0);
        rd(3'd6, v); chk("R6 mode off sets no flag", v, 16'h9000);
        idle(1);
        rd(3'd4, v); chk("R5 counting resumes after reload", v, 16'd1);
        @(negedge clk);
        wr(3'd2, 16'hFFFF);

        // R6 equal mode, R8 clearing
        quiesce(); wr(3'd0, 16'd5); wr(3'd6, 16'h8040); idle(4);
        rd(3'd6, v); chk("R6 equal flag not yet", v, 16'h9040);
        idle(3);
        rd(3'd6, v); chk("R6 equal flag set", v, 16'hB040);
        chk("R11 irq with flag1", {15'h0, irq}, 16'h1);
        @(negedge clk);
        wr(3'd6, 16'h8040);
        rd(3'd6, v); chk("R8 write 0 keeps flag", v, 16'hB040);
        @(negedge clk);
        wr(3'd6, 16'hA040);
        rd(3'd6, v); chk("R8 write 1 clears flag", v, 16'h9040);
        chk("R11 irq low after clear", {15'h0, irq}, 16'h0);
        @(negedge clk);

        // R6 greater-or-equal, R8 set wins
        quiesce(); wr(3'd0, 16'd3); wr(3'd6, 16'h8080); idle(2);
        rd(3'd6, v); chk("R6 ge flag not yet", v, 16'h9080);
        idle(3);
        rd(3'd6, v); chk("R6 ge flag set", v, 16'hB080);
        @(negedge clk);
        wr(3'd6, 16'hA080);
        rd(3'd6, v); chk("R8 set wins over clear", v, 16'hB080);
        @(negedge clk);

        // R7 event mode
        quiesce(); wr(3'd0, 16'd1); wr(3'd6, 16'h80C2); idle(6);
        rd(3'd4, v); chk("R7 counter at compare", v, 16'd1);
        rd(3'd6, v); chk("R7 event waits for tick", v, 16'h90C2);
        idle(2);
        rd(3'd6, v); chk("R7 event flag on tick", v, 16'hB0C2);
        @(negedge clk);

        // R9 stop enable
        quiesce(); wr(3'd2, 16'd4); wr(3'd6, 16'h8900); idle(10);
        rd(3'd4, v); chk("R9 stopped counter", v, 16'd0);
        rd(3'd6, v); chk("R9 flag2 set while stopped", v, 16'hD900);
        chk("R11 irq with flag2", {15'h0, irq}, 16'h1);
        @(negedge clk);
        wr(3'd6, 16'hC900); idle(2);
        rd(3'd4, v); chk("R9 resumes after clear", v, 16'd2);
        rd(3'd6, v); chk("R9 flag2 cleared", v, 16'h9900);
        @(negedge clk);

        // R12 watchdog arming
        quiesce(); rst_en = 1'b1;
        wr(3'd6, 16'h8100); wr(3'd4, 16'h0000); wr(3'd2, 16'd6);
        seen = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk); #2;
            if (sys_rst_req) begin seen = k; break; end
        end
        chk("R12 reset pulse timing", 16'(seen), 16'd6);
        @(negedge clk); #2;
        chk("R12 pulse lasts one cycle", {15'h0, sys_rst_req}, 16'h0);

        // R12 gated off by rst_en
        rst_en = 1'b0;
        quiesce();
        wr(3'd6, 16'h8100); wr(3'd4, 16'h0000); wr(3'd2, 16'd6);
        count_pulses(15, np);
        chk("R12 no pulse without rst_en", 16'(np), 16'd0);
        rd(3'd6, v); chk("R12 flag2 still rises", {15'h0, v[14]}, 16'h1);
        @(negedge clk);

        // R12 period zero
        quiesce(); rst_en = 1'b1;
        wr(3'd2, 16'h0000); wr(3'd6, 16'h8100);
        count_pulses(15, np);
        chk("R12 no pulse with zero period", 16'(np), 16'd0);
        rd(3'd6, v); chk("R12 zero period flag2", {15'h0, v[14]}, 16'h1);
        @(negedge clk);

        // random phase, checked per cycle against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (($urandom % 16) == 0) rst_en = $urandom % 2;
            addr = 3'($urandom % 8);
            if (($urandom % 4) == 0) begin
                wr_en = 1'b1;
                if (addr[2:1] == 2'd3)
                    wr_data = ($urandom & 16'hFFF0) | 16'($urandom % 3);
                else
                    wr_data = 16'($urandom % 12);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule